// File: doc/BRIEF.md
# Outbound Address Translator

This block sits between a 36-bit local bus and the request side of a serial I/O link, and turns each local address into a 64-bit link address. Four programmable windows each cover a power-of-two region of local space. A matching window replaces the address bits at and above its size with its own translated base. It also supplies the transaction type, memory or I/O, chosen separately for reads and for writes. A fifth slot, the default window, takes every request that no enabled window claims.

Software programs a window with a single write on the configuration port, and all fields of that window change together. The lookup itself is combinational. Its result is captured in one output register, so each request's translation appears exactly one cycle after the request is presented. When more than one window matches, the lowest-numbered window wins. This lets a small window placed in slot 0 carve an exception out of a larger window in a later slot.

Top module: `oat_xlate`

## Requirements
- R1: After a synchronous reset, out_valid is 0. All four windows are disabled. The default window has a translated base of zero, and both of its types are memory (0).
- R2: out_valid equals req_valid delayed by exactly one clock. out_addr, out_io, out_hit and out_win describe the request presented one cycle earlier.
- R3: Window i matches when it is enabled and local address bits 35 down to its size equal the same bits of its base. The local base is written as cfg_lbase, which holds local bits 35:12.
- R4: For the selected window of size s, out_addr bits below s come from the local address, and bits 63 down to s come from the translated base. The translated base is written as cfg_tbase, which holds link bits 63:12, and its bits below s are ignored. Local bits 11:0 always pass through unchanged.
- R5: When several enabled windows match, the lowest index wins. out_win reports that index (0..3) and out_hit is 1.
- R6: A disabled window never matches, whatever its base and size.
- R7: When no enabled window matches, the default window is used. In that case out_hit is 0, out_win is 4, and out_addr is {default base bits 63:36, local address}.
- R8: out_io gives the transaction type, 1 for I/O and 0 for memory. It takes the selected window's write type when req_write is 1 and its read type when req_write is 0.
- R9: The window size is written as log2 of the byte size. Values below 12 act as 12 (4 KB), and values above 36 act as 36 (64 GB).
- R10: A write with cfg_we at 1 updates window cfg_idx when cfg_idx is 0..3, or the default window (translated base and both types) when cfg_idx is 4. cfg_idx values 5..7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Window slot written (0..3 windows, 4 default) |
| cfg_en | input | 1 | Window enable |
| cfg_lbase | input | 24 | Local base, local address bits 35:12 |
| cfg_size | input | 6 | log2 of window size in bytes |
| cfg_tbase | input | 52 | Translated base, link address bits 63:12 |
| cfg_rd_io | input | 1 | Read type: 1 I/O, 0 memory |
| cfg_wr_io | input | 1 | Write type: 1 I/O, 0 memory |
| req_valid | input | 1 | Request present |
| req_addr | input | 36 | Local address |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| out_valid | output | 1 | Translation result valid |
| out_addr | output | 64 | Link address |
| out_io | output | 1 | Transaction type: 1 I/O, 0 memory |
| out_hit | output | 1 | 1 when a programmed window matched |
| out_win | output | 3 | Selected window index, 4 for the default |

## Verification
The bench sweeps addresses at, just below and just past each window's edges under several window layouts. One layout nests a 64 KB window inside a 1 MB window, and another adds a whole-space window behind them. A design that compared one bit too few or too many would send edge addresses to the wrong window. A design that got the priority order backwards would let the large window shadow the small one. One window is given a deliberately unaligned translated base, so a design that failed to mask the base below the window size would show stray upper bits. The bench also writes out-of-range sizes and unused slot indices, then re-sweeps to confirm clamping and that those writes are ignored.

// File: rtl/oat_pkg.sv
package oat_pkg;
    localparam int LA_W   = 36;
    localparam int XA_W   = 64;
    localparam int PG_W   = 12;
    localparam int LB_W   = LA_W - PG_W;
    localparam int TB_W   = XA_W - PG_W;
    localparam int EXT_W  = XA_W - LA_W;
    localparam int SZ_W   = 6;
    localparam int SZ_MIN = PG_W;
    localparam int SZ_MAX = LA_W;

    typedef struct packed {
        logic            en;
        logic [LB_W-1:0] lbase;
        logic [SZ_W-1:0] lsz;
        logic [TB_W-1:0] tbase;
        logic            rd_io;
        logic            wr_io;
    } win_t;

    localparam win_t WIN_RST = '{en: 1'b0, lbase: '0, lsz: SZ_W'(SZ_MAX),
                                 tbase: '0, rd_io: 1'b0, wr_io: 1'b0};

    function automatic logic [SZ_W-1:0] clamp_sz(input logic [SZ_W-1:0] s);
        if (s < SZ_W'(SZ_MIN))      return SZ_W'(SZ_MIN);
        else if (s > SZ_W'(SZ_MAX)) return SZ_W'(SZ_MAX);
        else                        return s;
    endfunction

    function automatic logic [XA_W-1:0] low_mask(input logic [SZ_W-1:0] s);
        return (XA_W'(1) << s) - XA_W'(1);
    endfunction
endpackage

// File: rtl/oat_win_match.sv
module oat_win_match
    import oat_pkg::*;
(
    input  win_t            win,
    input  logic [LA_W-1:0] addr,
    output logic            hit,
    output logic [XA_W-1:0] xaddr
);
    logic [XA_W-1:0] lm;
    logic [XA_W-1:0] a64;
    logic [XA_W-1:0] b64;

    always_comb begin
        lm    = low_mask(win.lsz);
        a64   = {{EXT_W{1'b0}}, addr};
        b64   = {{EXT_W{1'b0}}, win.lbase, {PG_W{1'b0}}};
        hit   = win.en && (((a64 ^ b64) & ~lm) == '0);
        xaddr = ({win.tbase, {PG_W{1'b0}}} & ~lm) | (a64 & lm);
    end
endmodule

// File: rtl/oat_prio_pick.sv
module oat_prio_pick #(
    parameter int N    = 5,
    parameter int IW   = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx
);
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/oat_xlate.sv
module oat_xlate
    import oat_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = $clog2(NUM_WIN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_en,
    input  logic [LB_W-1:0]  cfg_lbase,
    input  logic [SZ_W-1:0]  cfg_size,
    input  logic [TB_W-1:0]  cfg_tbase,
    input  logic             cfg_rd_io,
    input  logic             cfg_wr_io,
    input  logic             req_valid,
    input  logic [LA_W-1:0]  req_addr,
    input  logic             req_write,
    output logic             out_valid,
    output logic [XA_W-1:0]  out_addr,
    output logic             out_io,
    output logic             out_hit,
    output logic [IDX_W-1:0] out_win
);
    localparam int NSLOT = NUM_WIN + 1;

    win_t            tbl [NUM_WIN];
    logic [TB_W-1:0] dft_tbase;
    logic            dft_rio, dft_wio;
    win_t            slot [NSLOT];
    logic [NSLOT-1:0] hits, gnt;
    logic [XA_W-1:0] xa [NSLOT];
    logic [IDX_W-1:0] sel;
    logic [NUM_WIN-1:0] en_vec;

    // window table, one write updates a whole slot (R10, size clamp R9)
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WIN; i++) tbl[i] <= WIN_RST;
            dft_tbase <= '0;
            dft_rio   <= 1'b0;
            dft_wio   <= 1'b0;
        end else if (cfg_we) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (cfg_idx == IDX_W'(i)) begin
                    tbl[i] <= '{en: cfg_en, lbase: cfg_lbase, lsz: clamp_sz(cfg_size),
                                tbase: cfg_tbase, rd_io: cfg_rd_io, wr_io: cfg_wr_io};
                end
            end
            if (cfg_idx == IDX_W'(NUM_WIN)) begin
                dft_tbase <= cfg_tbase;
                dft_rio   <= cfg_rd_io;
                dft_wio   <= cfg_wr_io;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_WIN; i++) begin
            slot[i]   = tbl[i];
            en_vec[i] = tbl[i].en;
        end
        slot[NUM_WIN] = '{en: 1'b1, lbase: '0, lsz: SZ_W'(SZ_MAX),
                          tbase: dft_tbase, rd_io: dft_rio, wr_io: dft_wio};
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_match
        oat_win_match u_match (
            .win   (slot[g]),
            .addr  (req_addr),
            .hit   (hits[g]),
            .xaddr (xa[g])
        );
    end

    oat_prio_pick #(.N(NSLOT), .IW(IDX_W)) u_pick (
        .req (hits),
        .gnt (gnt),
        .idx (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_io    <= 1'b0;
            out_hit   <= 1'b0;
            out_win   <= '0;
        end else begin
            out_valid <= req_valid;
            out_addr  <= xa[sel];
            out_io    <= req_write ? slot[sel].wr_io : slot[sel].rd_io;
            out_hit   <= (sel != IDX_W'(NUM_WIN));
            out_win   <= sel;
        end
    end

    assert_reset_R1: assert property (@(posedge clk) $past(rst) |-> !out_valid);
    assert_lat_on_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    assert_lat_off_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);
    assert_low_pass_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_addr[PG_W-1:0] == $past(req_addr[PG_W-1:0]));
    assert_one_grant_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot(gnt));
    assert_hit_index_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_hit |-> out_win < IDX_W'(NUM_WIN));
    assert_enabled_only_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !out_hit || ((($past(en_vec) >> out_win) & NUM_WIN'(1)) != '0));
    assert_default_idx_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_hit |-> out_win == IDX_W'(NUM_WIN));
endmodule

// File: tb/oat_xlate_bench.sv
module oat_xlate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic [23:0] cfg_lbase = '0;
    logic [5:0]  cfg_size = '0;
    logic [51:0] cfg_tbase = '0;
    logic        cfg_rd_io = 1'b0, cfg_wr_io = 1'b0;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        out_valid, out_io, out_hit;
    logic [63:0] out_addr;
    logic [2:0]  out_win;

    int checks = 0, fails = 0;
    bit finished = 0;

    // bench-side model of the window table
    bit          m_en  [4];
    logic [23:0] m_base[4];
    int          m_sz  [4];
    logic [51:0] m_tgt [4];
    bit          m_rio [4], m_wio [4];
    logic [51:0] m_dt = '0;
    bit          m_drio = 0, m_dwio = 0;

    oat_xlate u_oat_xlate (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
        .cfg_lbase(cfg_lbase), .cfg_size(cfg_size), .cfg_tbase(cfg_tbase),
        .cfg_rd_io(cfg_rd_io), .cfg_wr_io(cfg_wr_io), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .out_valid(out_valid),
        .out_addr(out_addr), .out_io(out_io), .out_hit(out_hit), .out_win(out_win)
    );

    always #2 clk = ~clk;

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        report();
    end

    task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input bit en, input logic [23:0] lb, input int sz,
                       input logic [51:0] tb, input bit rio, input bit wio);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_en = en; cfg_lbase = lb; cfg_size = 6'(sz);
        cfg_tbase = tb; cfg_rd_io = rio; cfg_wr_io = wio;
        @(negedge clk);
        cfg_we = 0;
        // R10 slot mapping, R9 clamp
        if (idx < 4) begin
            m_en[idx] = en; m_base[idx] = lb; m_tgt[idx] = tb;
            m_rio[idx] = rio; m_wio[idx] = wio;
            m_sz[idx] = (sz < 12) ? 12 : (sz > 36) ? 36 : sz;
        end else if (idx == 4) begin
            m_dt = tb; m_drio = rio; m_dwio = wio;
        end
    endtask

    task automatic req(input logic [35:0] a, input bit w, input string tag);
        logic [63:0] ea, a64, t64;
        bit eio, ehit;
        int ew;
        req_valid = 1; req_addr = a; req_write = w;
        @(negedge clk);
        a64 = {28'b0, a};
        ehit = 0; ew = 4;
        ea = (({m_dt, 12'b0} >> 36) << 36) | a64;
        eio = w ? m_dwio : m_drio;
        for (int i = 0; i < 4; i++) begin
            if (!ehit && m_en[i] && ((a64 >> m_sz[i]) == ({28'b0, m_base[i], 12'b0} >> m_sz[i]))) begin
                ehit = 1; ew = i;
                t64 = {m_tgt[i], 12'b0};
                ea = ((t64 >> m_sz[i]) << m_sz[i]) | (a64 % (64'd1 << m_sz[i]));
                eio = w ? m_wio[i] : m_rio[i];
            end
        end
        chk(out_valid && out_addr == ea && out_io == eio && out_hit == ehit && out_win == 3'(ew),
            $sformatf("%s addr=%0h wr=%0d {valid,hit,win,io,addr}", tag, a, w),
            {out_valid, out_hit, out_win, out_io, out_addr},
            {1'b1, ehit, 3'(ew), eio, ea});
        req_valid = 0;
    endtask

    function automatic logic [35:0] pick_base(input int k);
        case (k)
            0: return 36'h0_1234_0000;
            1: return 36'h0_1230_0000;
            2: return 36'h8_0000_0000;
            3: return 36'h0_0000_0000;
            4: return 36'hF_FFFF_F000;
            default: return 36'h0_1240_0000;
        endcase
    endfunction

    function automatic logic [35:0] pick_off(input int k);
        case (k)
            0: return 36'h0;
            1: return 36'h1;
            2: return 36'hFFF;
            3: return 36'h1000;
            4: return 36'hFFFF;
            5: return 36'h10000;
            6: return 36'hFFFFF;
            default: return 36'h100000;
        endcase
    endfunction

    task automatic sweep(input string tag);
        for (int b = 0; b < 6; b++)
            for (int o = 0; o < 8; o++)
                for (int w = 0; w < 2; w++) begin
                    req(pick_base(b) + pick_off(o), w[0], tag);
                    req(pick_base(b) - pick_off(o) - 36'h1, w[0], tag);
                end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_en[i] = 0; m_base[i] = '0; m_sz[i] = 36; m_tgt[i] = '0; m_rio[i] = 0; m_wio[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(out_valid == 0, "R1 out_valid after reset", 128'(out_valid), 128'(0));
        req(36'h9_8765_4321, 0, "R1 reset table default");
        // R2: idle cycle gives no valid
        @(negedge clk);
        chk(out_valid == 0, "R2 idle cycle out_valid", 128'(out_valid), 128'(0));

        // R3 R4 R5 R7 R8: nested windows, unaligned target on W1
        cfg(0, 1, 24'h012340, 16, 52'hABCD0_0000_0000, 0, 0);
        cfg(1, 1, 24'h012300, 20, 52'h1111_2222_3333_4, 1, 0);
        cfg(2, 0, 24'h000000, 36, 52'h7000_0000_0000_0, 1, 1);
        cfg(3, 1, 24'h800000, 12, 52'hFEDC_BA98_7654_3, 0, 1);
        cfg(4, 0, 24'hFFFFFF, 20, 52'h5555_6666_7777_8, 1, 0);
        sweep("R3 R4 R5 R7 R8 base layout");
        req(36'h0_1234_5678, 1, "R2 back-to-back first");
        req(36'h0_1234_5679, 0, "R2 back-to-back second");

        // R5 R6: whole-space window behind the others
        cfg(2, 1, 24'h000000, 36, 52'h7000_0000_0000_0, 1, 1);
        sweep("R5 R6 whole-space W2");
        // R6: W0 disabled, W1 covers its range
        cfg(0, 0, 24'h012340, 16, 52'hABCD0_0000_0000, 0, 0);
        sweep("R6 W0 disabled");

        // R9: size clamping
        cfg(2, 0, 24'h000000, 36, 52'h7000_0000_0000_0, 1, 1);
        cfg(3, 1, 24'h800000, 5, 52'hFEDC_BA98_7654_3, 0, 1);
        sweep("R9 size below 12");
        cfg(3, 1, 24'h800000, 40, 52'hFEDC_BA98_7654_3, 1, 0);
        sweep("R9 size above 36");

        // R10: writes to slots 5..7 are ignored
        cfg(5, 1, 24'h012340, 12, 52'hFFFF_FFFF_FFFF_F, 1, 1);
        cfg(7, 1, 24'h000000, 36, 52'hFFFF_FFFF_FFFF_F, 1, 1);
        sweep("R10 ignored slot writes");
        report();
    end
endmodule